// File: doc/BRIEF.md
# Banked Strided and Indexed Vector Access Engine

This block moves a short vector between a local vector buffer and a memory made of several independently accessible banks. Consecutive word addresses are interleaved across the banks, so the bank is chosen by the low address bits. A single command picks how element addresses are formed and which way the data moves. In strided mode each address is a base plus a constant stride per element. In indexed mode each address is the base plus an entry from a small index list, so the addresses can be irregular. The data moves in one of two directions. Gather reads memory into the buffer, and scatter writes buffer contents out to memory.

Each bank needs a recovery interval of RECOVER cycles between two accesses. The engine issues at most one element per cycle and keeps strict element order. When the next element falls in a bank that is still recovering, the engine waits for that bank. It does not skip ahead to a later element. As a result, streams that visit the banks in rotation run at full rate, and streams that keep hitting one bank slow down to the recovery interval. The host loads the index list and the buffer through simple write ports, starts a command, waits for the done pulse, and then reads the buffer back.

Top module: `strided_bank_engine`

## Requirements
- R1: After reset, `busy` and `done` are low.
- R2: An element address selects bank `addr % NBANK` and row `addr / NBANK` (NBANK is a power of two). Address arithmetic wraps modulo 2^ADDR_W.
- R3: In strided mode (`cmd_indexed`=0), element k uses address `base + k*stride`.
- R4: In indexed mode (`cmd_indexed`=1), element k uses address `base + index[k]`, where `index[k]` is the value last written to index slot k.
- R5: A gather (`cmd_write`=0) places the word read for element k in buffer slot k. A scatter (`cmd_write`=1) stores buffer slot k at element k's address. When a scatter writes the same address twice, the higher element number wins.
- R6: Elements issue one per cycle in increasing element order whenever their bank is free. No later element issues before an earlier one.
- R7: Two accesses to the same bank are at least RECOVER cycles apart. An element whose bank is recovering stalls the whole stream.
- R8: `done` is a one-cycle pulse that coincides with `busy` falling. Count clock edges from the edge that accepts the command. A scatter pulses `done` one edge after its last issue. A gather pulses it two edges after its last issue. A zero-length command pulses it on the first edge after acceptance.
- R9: A command presented while `busy` is high is ignored. It changes neither the running transfer nor its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Start a command (accepted only while idle) |
| cmd_indexed | input | 1 | 0 strided, 1 indexed addressing |
| cmd_write | input | 1 | 0 gather into buffer, 1 scatter from buffer |
| cmd_base | input | ADDR_W | Base word address |
| cmd_stride | input | ADDR_W | Stride in words (strided mode) |
| cmd_len | input | LEN_W | Number of elements, 0..VLEN |
| idx_we | input | 1 | Write an index list entry |
| idx_slot | input | SLOT_W | Index list entry number |
| idx_val | input | ADDR_W | Index value (word offset from base) |
| buf_we | input | 1 | Host write into the vector buffer |
| buf_wslot | input | SLOT_W | Buffer slot written by the host |
| buf_wdata | input | DATA_W | Data written by the host |
| buf_rslot | input | SLOT_W | Buffer slot to read |
| buf_rdata | output | DATA_W | Buffer slot contents (combinational) |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest conditions to produce are stall patterns in which the bank being waited on is not the only bank in play. One example is an index list that returns to a bank at once while the element after it targets a free bank. That is the only case in which out-of-order issue could be observed. The stimulus builds such lists on purpose, along with strides that land every element in one bank and strides that alternate between two banks inside the recovery window. It then compares the exact completion cycle count, together with the buffer contents, against values derived from the recovery rule. A second command is also injected in the middle of a transfer, and the test confirms that neither the timing nor the data changes.

// File: rtl/strided_bank_engine.sv
module strided_bank_engine #(
  parameter int NBANK   = 4,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16,
  parameter int VLEN    = 16,
  parameter int RECOVER = 3,
  localparam int LEN_W  = $clog2(VLEN + 1),
  localparam int SLOT_W = $clog2(VLEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_indexed,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [ADDR_W-1:0] cmd_stride,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              idx_we,
  input  logic [SLOT_W-1:0] idx_slot,
  input  logic [ADDR_W-1:0] idx_val,
  input  logic              buf_we,
  input  logic [SLOT_W-1:0] buf_wslot,
  input  logic [DATA_W-1:0] buf_wdata,
  input  logic [SLOT_W-1:0] buf_rslot,
  output logic [DATA_W-1:0] buf_rdata,
  output logic              busy,
  output logic              done
);
  localparam int BANK_W = $clog2(NBANK);
  localparam int ROW_W  = ADDR_W - BANK_W;
  localparam int ROWS   = 1 << ROW_W;
  localparam int CNT_W  = $clog2(RECOVER + 1);

  logic              mode_q, wr_q;
  logic [ADDR_W-1:0] base_q, stride_q, walk;
  logic [LEN_W-1:0]  len_q, k;
  logic              rd_v;
  logic [SLOT_W-1:0] rd_slot;
  logic [DATA_W-1:0] rd_data;

  logic [DATA_W-1:0] mem    [NBANK][ROWS];
  logic [DATA_W-1:0] vbuf   [VLEN];
  logic [ADDR_W-1:0] idx_mem[VLEN];
  logic [CNT_W-1:0]  cnt    [NBANK];

  logic [SLOT_W-1:0] slot;
  logic [ADDR_W-1:0] addr;
  logic [BANK_W-1:0] bsel;
  logic [ROW_W-1:0]  rsel;
  logic              want, issue, finish;

  assign slot   = k[SLOT_W-1:0];
  assign addr   = mode_q ? base_q + idx_mem[slot] : walk;
  assign bsel   = addr[BANK_W-1:0];
  assign rsel   = addr[ADDR_W-1:BANK_W];
  assign want   = busy && (k < len_q);
  assign issue  = want && (cnt[bsel] == '0);
  assign finish = busy && !want && !rd_v;
  assign buf_rdata = vbuf[buf_rslot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      rd_v     <= 1'b0;
      k        <= '0;
      len_q    <= '0;
      mode_q   <= 1'b0;
      wr_q     <= 1'b0;
      base_q   <= '0;
      stride_q <= '0;
      walk     <= '0;
    end else begin
      done <= 1'b0;
      rd_v <= issue && !wr_q;
      if (!busy && cmd_valid) begin
        busy     <= 1'b1;
        mode_q   <= cmd_indexed;
        wr_q     <= cmd_write;
        base_q   <= cmd_base;
        stride_q <= cmd_stride;
        len_q    <= cmd_len;
        walk     <= cmd_base;
        k        <= '0;
      end else if (issue) begin
        k    <= k + 1'b1;
        walk <= walk + stride_q;
      end else if (finish) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)                              cnt[b] <= '0;
      else if (issue && bsel == BANK_W'(b))    cnt[b] <= CNT_W'(RECOVER - 1);
      else if (cnt[b] != '0)                   cnt[b] <= cnt[b] - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (issue) begin
      if (wr_q) mem[bsel][rsel] <= vbuf[slot];
      else      rd_data         <= mem[bsel][rsel];
      rd_slot <= slot;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_v)        vbuf[rd_slot]   <= rd_data;
    else if (buf_we) vbuf[buf_wslot] <= buf_wdata;
  end

  always_ff @(posedge clk) begin
    if (idx_we) idx_mem[idx_slot] <= idx_val;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !busy && !done); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy && $past(busy)); // R8
  AST_K_BOUND: assert property (@(posedge clk) disable iff (!rst_n) busy |-> k <= len_q); // R6
  AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n) $past(issue) |-> k == $past(k) + 1'b1); // R6
  AST_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (busy && cmd_valid) |=> $stable(len_q) && $stable(base_q) && $stable(wr_q)); // R9

  if (RECOVER > 1) begin : g_rec_chk
    AST_BANK_RECOVER: assert property (@(posedge clk) disable iff (!rst_n) (issue && $past(issue)) |-> bsel != $past(bsel)); // R7
  end
endmodule

// File: tb/test_strided_bank_engine.sv
module test_strided_bank_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NBANK = 4, ADDR_W = 6, DATA_W = 16, VLEN = 16, RECOVER = 3;
  localparam int LEN_W = $clog2(VLEN + 1), SLOT_W = $clog2(VLEN);

  typedef struct packed {
    logic        wr;
    logic        ix;
    logic [5:0]  base;
    logic [5:0]  stride;
    logic [4:0]  len;
    logic [23:0] idx;
    logic [7:0]  cyc;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 6'd0,  6'd1, 5'd16, 24'd0, 8'd17},
    '{1'b1, 1'b0, 6'd16, 6'd1, 5'd16, 24'd0, 8'd17},
    '{1'b1, 1'b0, 6'd32, 6'd1, 5'd16, 24'd0, 8'd17},
    '{1'b1, 1'b0, 6'd48, 6'd1, 5'd16, 24'd0, 8'd17},
    '{1'b0, 1'b0, 6'd0,  6'd1, 5'd16, 24'd0, 8'd18},
    '{1'b0, 1'b0, 6'd2,  6'd4, 5'd4,  24'd0, 8'd12},
    '{1'b0, 1'b0, 6'd0,  6'd5, 5'd8,  24'd0, 8'd10},
    '{1'b0, 1'b1, 6'd0,  6'd0, 5'd4,  {6'd7, 6'd3, 6'd1, 6'd0}, 8'd8},
    '{1'b0, 1'b1, 6'd8,  6'd0, 5'd3,  {6'd0, 6'd1, 6'd4, 6'd0}, 8'd7},
    '{1'b1, 1'b0, 6'd1,  6'd2, 5'd6,  24'd0, 8'd9},
    '{1'b0, 1'b0, 6'd1,  6'd2, 5'd6,  24'd0, 8'd10},
    '{1'b0, 1'b0, 6'd0,  6'd1, 5'd0,  24'd0, 8'd1},
    '{1'b0, 1'b0, 6'd62, 6'd1, 5'd4,  24'd0, 8'd6},
    '{1'b1, 1'b1, 6'd0,  6'd0, 5'd2,  {6'd0, 6'd0, 6'd5, 6'd5}, 8'd5},
    '{1'b0, 1'b0, 6'd4,  6'd1, 5'd4,  24'd0, 8'd6}
  };

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_indexed = 0, cmd_write = 0;
  logic [ADDR_W-1:0] cmd_base = '0, cmd_stride = '0;
  logic [LEN_W-1:0]  cmd_len = '0;
  logic idx_we = 0, buf_we = 0;
  logic [SLOT_W-1:0] idx_slot = '0, buf_wslot = '0, buf_rslot = '0;
  logic [ADDR_W-1:0] idx_val = '0;
  logic [DATA_W-1:0] buf_wdata = '0, buf_rdata;
  logic busy, done;

  int checks = 0, errors = 0, cyc = 0;
  logic [DATA_W-1:0] mem_m [64];

  strided_bank_engine #(.NBANK(NBANK), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                        .VLEN(VLEN), .RECOVER(RECOVER)) i_strided_bank_engine (
    .clk, .rst_n, .cmd_valid, .cmd_indexed, .cmd_write, .cmd_base, .cmd_stride,
    .cmd_len, .idx_we, .idx_slot, .idx_val, .buf_we, .buf_wslot, .buf_wdata,
    .buf_rslot, .buf_rdata, .busy, .done);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start(input vec_t v);
    @(negedge clk);
    cmd_valid = 1; cmd_indexed = v.ix; cmd_write = v.wr;
    cmd_base = v.base; cmd_stride = v.stride; cmd_len = v.len;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  function automatic logic [5:0] elem_addr(input vec_t v, input int k);
    logic [5:0] off;
    off = v.idx[k*6 +: 6];
    return v.ix ? 6'(v.base + off) : 6'(v.base + k * v.stride);
  endfunction

  task automatic prep(input vec_t v, input int t);
    if (v.ix)
      for (int k = 0; k < 4; k++) begin
        @(negedge clk); idx_we = 1; idx_slot = SLOT_W'(k); idx_val = v.idx[k*6 +: 6];
      end
    if (v.wr)
      for (int k = 0; k < int'(v.len); k++) begin
        @(negedge clk); buf_we = 1; buf_wslot = SLOT_W'(k);
        buf_wdata = DATA_W'(t*256 + k*7 + 3);
        mem_m[elem_addr(v, k)] = DATA_W'(t*256 + k*7 + 3);
      end
    @(negedge clk); idx_we = 0; buf_we = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_buf(input vec_t v, input string req);
    for (int k = 0; k < int'(v.len); k++) begin
      buf_rslot = SLOT_W'(k);
      #1;
      chk(buf_rdata == mem_m[elem_addr(v, k)], req, buf_rdata, mem_m[elem_addr(v, k)]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R1 reset idle", {busy, done}, 0);
    rst_n = 1;

    for (int t = 0; t < NV; t++) begin
      vec_t v;
      int c;
      v = TBL[t];
      prep(v, t);
      start(v);
      c = 0;
      while (!done && c < 1000) begin @(negedge clk); c++; end
      chk(c == int'(v.cyc), "R6 R7 R8 completion cycles", c, v.cyc);
      @(negedge clk);
      chk(done == 0 && busy == 0, "R8 done single pulse", {busy, done}, 0);
      if (!v.wr) check_buf(v, v.ix ? "R4 R5 gather data" : "R2 R3 R5 gather data");
    end

    begin
      vec_t v;
      int c;
      v = TBL[4];
      repeat (2) @(negedge clk);
      start(v);
      c = 0;
      repeat (3) begin @(negedge clk); c++; end
      cmd_valid = 1; cmd_write = 1; cmd_base = 6'd5; cmd_len = '0;
      @(negedge clk); c++;
      cmd_valid = 0; cmd_write = 0;
      while (!done && c < 1000) begin @(negedge clk); c++; end
      chk(c == 18, "R9 busy command ignored timing", c, 18);
      check_buf(v, "R9 busy command ignored data");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule